// File: doc/BRIEF.md
# Retired-Instruction Dataflow Slice Extractor

This block watches the stream of instructions that leave the core in program order and keeps the most recent ones in a history buffer. Each stored instruction carries its destination and source registers, a few flags set during execution, and a scope flag. The flags mark a load, a store, a load whose data came through memory from an earlier store, confidence of the value predictor and confidence of the address predictor.

When a promotion request arrives for a hard-to-predict branch that has just retired, the buffer is frozen. A scanner then walks from the youngest entry toward the oldest, one entry per cycle. It keeps a set of registers whose producers are still wanted and emits the backward dataflow slice that computes the branch, as a numbered list of micro-ops. Value-confident producers become value-predict micro-ops. Address-confident loads become loads with a predicted address, and the computation feeding them is cut away. The branch itself becomes a prediction-write micro-op.

The walk ends at the first of four events: the scope ends, a store that satisfies a memory dependency is met, the construction buffer is full, or the oldest entry has been visited. The block then reports the stop cause, the micro-op count and the age of the earliest legal spawn point, and a single slice is built at a time.

Top module: `slice_extractor`

## Requirements
- R1: While the block is ready, each cycle with `ret_vld` high and `req_vld` low stores one instruction as the new youngest entry (age 0). The oldest entry is discarded once DEPTH entries are held. Only ages below the number of stored entries count as present.
- R2: `req_rdy` is high out of reset and falls in the cycle after a request is accepted (`req_vld` high while `req_rdy` high). It stays low until the cycle in which `done` pulses, and is high again in that cycle. Retires offered while `req_rdy` is low, or in the cycle of an accepted request, are dropped and do not change the buffer.
- R3: After an accepted request the scanner visits ages 0, 1, 2 … one per cycle. `done` is high for exactly one cycle, V+1 cycles after the accept cycle, where V is the number of entries visited including the entry that stopped the walk.
- R4: Age 0 is always the terminating branch. It is emitted in slot 0 with kind 3 (prediction write), `uop_dst` = 0 and its own sources. Those sources form the initial needed-register set.
- R5: An older entry is needed when it has a destination whose bit is set in the needed set. A needed entry that is not pruned is emitted with kind 0 (copy) and its own destination and sources. Its destination bit is cleared and then its source bits are set, so a source equal to the destination stays needed. Entries that are not needed are skipped.
- R6: A needed entry flagged value-confident is emitted with kind 1 (value predict) and no sources. Its destination bit is cleared and no source bit is set.
- R7: A needed load flagged address-confident (and not value-confident) is emitted with kind 2 (load at predicted address) and no sources. Its base computation is not followed.
- R8: An entry at age ≥ 1 that is not present or has its scope flag clear stops the walk with stop cause 1. It is not emitted, and the spawn age is its age minus one. This check has the highest precedence.
- R9: Once a needed load flagged as memory-dependent has been emitted as kind 0 or 2, the next older store entry stops the walk with stop cause 2. The store is not emitted, and the spawn age is its age minus one.
- R10: A needed entry met while CB_DEPTH micro-ops have already been emitted stops the walk with stop cause 3. It is not emitted, and the spawn age is its age minus one. This check ranks below R8 and R9.
- R11: When age DEPTH−1 is visited without a stop, the walk ends with stop cause 0 and spawn age DEPTH−1.
- R12: Emitted micro-ops carry consecutive slot numbers from 0 in scan order. `uop_total` equals their count while `done` is high. Source fields not marked present read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ret_vld | input | 1 | A retired instruction is offered |
| ret_dst | input | RW | Destination register |
| ret_has_dst | input | 1 | Destination present |
| ret_src0 | input | RW | First source register (base register for a load) |
| ret_has_src0 | input | 1 | First source present |
| ret_src1 | input | RW | Second source register |
| ret_has_src1 | input | 1 | Second source present |
| ret_is_load | input | 1 | Instruction is a load |
| ret_is_store | input | 1 | Instruction is a store |
| ret_mem_dep | input | 1 | Load data came from an earlier store |
| ret_in_scope | input | 1 | Instruction lies in the path scope |
| ret_val_conf | input | 1 | Value predictor is confident for the result |
| ret_addr_conf | input | 1 | Address predictor is confident for the load |
| req_vld | input | 1 | Promotion request |
| req_rdy | output | 1 | Block idle and able to accept a request |
| uop_vld | output | 1 | A micro-op is emitted this cycle |
| uop_slot | output | CBW | Slot number of the micro-op |
| uop_kind | output | 2 | 0 copy, 1 value predict, 2 predicted-address load, 3 prediction write |
| uop_dst | output | RW | Destination register of the micro-op |
| uop_src0 | output | RW | First source register |
| uop_has_src0 | output | 1 | First source present |
| uop_src1 | output | RW | Second source register |
| uop_has_src1 | output | 1 | Second source present |
| done | output | 1 | Single-cycle end-of-build pulse |
| spawn_age | output | AW | Age of the earliest legal spawn instruction |
| uop_total | output | CW | Number of micro-ops emitted |
| stop_why | output | 2 | 0 end of buffer, 1 scope, 2 memory dependency, 3 full |

## Verification
The assertions check four things on every cycle. The buffer head stays fixed while the block is busy. The first micro-op after an accept is the prediction write in slot 0. Pruned micro-ops never carry sources, and `done` is a lone pulse that never reports more micro-ops than the construction buffer holds. The slice contents, the needed-set updates, the precedence among the stop causes, the spawn age and the visit count all depend on the whole history. They are shown only by the bench's scenarios, which compare every emitted micro-op and the final report against a model of the scan.

// File: rtl/slx_pkg.sv
package slx_pkg;

  typedef enum logic [1:0] {
    UK_COPY   = 2'd0,
    UK_VPRED  = 2'd1,
    UK_APLOAD = 2'd2,
    UK_PWRITE = 2'd3
  } uop_kind_e;

  typedef enum logic [1:0] {
    SW_END    = 2'd0,
    SW_SCOPE  = 2'd1,
    SW_MEMDEP = 2'd2,
    SW_FULL   = 2'd3
  } stop_why_e;

  typedef struct packed {
    logic has_dst;
    logic has_s0;
    logic has_s1;
    logic is_load;
    logic is_store;
    logic mem_dep;
    logic in_scope;
    logic val_conf;
    logic addr_conf;
  } ent_flags_t;

  // micro-op kind of an accepted entry
  function automatic uop_kind_e pick_kind(input ent_flags_t f, input logic is_branch);
    if (is_branch)                   return UK_PWRITE;
    else if (f.val_conf)             return UK_VPRED;
    else if (f.is_load && f.addr_conf) return UK_APLOAD;
    else                             return UK_COPY;
  endfunction

  // sources of the micro-op are followed only for copies and the branch
  function automatic logic keeps_sources(input uop_kind_e k);
    return (k == UK_COPY) || (k == UK_PWRITE);
  endfunction

  // an accepted load whose data travelled through memory opens a store wait
  function automatic logic opens_memdep(input ent_flags_t f);
    return f.is_load && f.mem_dep && !f.val_conf;
  endfunction

endpackage

// File: rtl/slx_history.sv
module slx_history
  import slx_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int RW    = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_dst,
  input  logic [RW-1:0] wr_s0,
  input  logic [RW-1:0] wr_s1,
  input  ent_flags_t    wr_flg,
  input  logic [AW-1:0] rd_age,
  output logic          rd_valid,
  output logic [RW-1:0] rd_dst,
  output logic [RW-1:0] rd_s0,
  output logic [RW-1:0] rd_s1,
  output ent_flags_t    rd_flg,
  output logic [AW-1:0] head
);

  logic [RW-1:0] dst_m [DEPTH];
  logic [RW-1:0] s0_m  [DEPTH];
  logic [RW-1:0] s1_m  [DEPTH];
  ent_flags_t    flg_m [DEPTH];

  logic [AW-1:0] head_q;
  logic [AW:0]   fill_q;
  logic [AW-1:0] rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      fill_q <= '0;
    end else if (wr_en) begin
      head_q <= head_q + AW'(1);
      if (fill_q != (AW+1)'(DEPTH)) fill_q <= fill_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dst_m[head_q] <= wr_dst;
      s0_m[head_q]  <= wr_s0;
      s1_m[head_q]  <= wr_s1;
      flg_m[head_q] <= wr_flg;
    end
  end

  // age 0 is the slot just behind the write head
  assign rd_addr  = head_q - AW'(1) - rd_age;
  assign rd_valid = ({1'b0, rd_age} < fill_q);
  assign rd_dst   = dst_m[rd_addr];
  assign rd_s0    = s0_m[rd_addr];
  assign rd_s1    = s1_m[rd_addr];
  assign rd_flg   = flg_m[rd_addr];
  assign head     = head_q;

endmodule

// File: rtl/slx_pick.sv
module slx_pick
  import slx_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            is_first,
  input  logic            ent_valid,
  input  logic [RW-1:0]   dst,
  input  logic [RW-1:0]   s0,
  input  logic [RW-1:0]   s1,
  input  ent_flags_t      flg,
  input  logic [NREG-1:0] need,
  input  logic            mem_pend,
  input  logic            cb_full,
  output logic            take,
  output logic            stop,
  output stop_why_e       why,
  output uop_kind_e       kind,
  output logic [NREG-1:0] need_nx,
  output logic            opens_mem,
  output logic [RW-1:0]   u_dst,
  output logic [RW-1:0]   u_s0,
  output logic            u_h0,
  output logic [RW-1:0]   u_s1,
  output logic            u_h1
);

  logic needed, hit, keep_src;

  assign needed   = flg.has_dst && need[dst];
  assign hit      = is_first || needed;
  assign kind     = pick_kind(flg, is_first);
  assign keep_src = keeps_sources(kind);

  always_comb begin
    stop = 1'b0;
    why  = SW_END;
    if (!is_first) begin
      if (!ent_valid || !flg.in_scope) begin
        stop = 1'b1;
        why  = SW_SCOPE;
      end else if (mem_pend && flg.is_store) begin
        stop = 1'b1;
        why  = SW_MEMDEP;
      end else if (needed && cb_full) begin
        stop = 1'b1;
        why  = SW_FULL;
      end
    end
  end

  assign take = hit && !stop;

  always_comb begin
    need_nx = need;
    if (!is_first) need_nx[dst] = 1'b0;
    if (keep_src && flg.has_s0) need_nx[s0] = 1'b1;
    if (keep_src && flg.has_s1) need_nx[s1] = 1'b1;
  end

  assign opens_mem = !is_first && opens_memdep(flg);
  assign u_h0  = keep_src && flg.has_s0;
  assign u_h1  = keep_src && flg.has_s1;
  assign u_s0  = u_h0 ? s0 : '0;
  assign u_s1  = u_h1 ? s1 : '0;
  assign u_dst = is_first ? '0 : dst;

endmodule

// File: rtl/slx_scan.sv
module slx_scan
  import slx_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int CB_DEPTH = 32,
  parameter int NREG     = 32,
  localparam int AW      = $clog2(DEPTH),
  localparam int RW      = $clog2(NREG),
  localparam int CBW     = (CB_DEPTH > 1) ? $clog2(CB_DEPTH) : 1,
  localparam int CW      = $clog2(CB_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  output logic            req_rdy,
  output logic [AW-1:0]   age,
  output logic            is_first,
  output logic [NREG-1:0] need,
  output logic            mem_pend,
  output logic            cb_full,
  input  logic            take,
  input  logic            stop,
  input  stop_why_e       why,
  input  uop_kind_e       kind,
  input  logic [NREG-1:0] need_nx,
  input  logic            opens_mem,
  input  logic [RW-1:0]   u_dst,
  input  logic [RW-1:0]   u_s0,
  input  logic            u_h0,
  input  logic [RW-1:0]   u_s1,
  input  logic            u_h1,
  output logic            uop_vld,
  output logic [CBW-1:0]  uop_slot,
  output logic [1:0]      uop_kind,
  output logic [RW-1:0]   uop_dst,
  output logic [RW-1:0]   uop_src0,
  output logic            uop_has_src0,
  output logic [RW-1:0]   uop_src1,
  output logic            uop_has_src1,
  output logic            done,
  output logic [AW-1:0]   spawn_age,
  output logic [CW-1:0]   uop_total,
  output logic [1:0]      stop_why
);

  logic busy_q, accept, at_end, finish;
  logic [AW-1:0] age_q;
  logic [CW-1:0] cnt_q;

  assign accept   = req_vld && !busy_q;
  assign req_rdy  = !busy_q;
  assign at_end   = (age_q == AW'(DEPTH - 1));
  assign finish   = busy_q && (stop || at_end);
  assign age      = age_q;
  assign is_first = (age_q == '0);
  assign cb_full  = (cnt_q == CW'(CB_DEPTH));
  assign uop_total = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      age_q        <= '0;
      cnt_q        <= '0;
      need         <= '0;
      mem_pend     <= 1'b0;
      uop_vld      <= 1'b0;
      uop_slot     <= '0;
      uop_kind     <= '0;
      uop_dst      <= '0;
      uop_src0     <= '0;
      uop_has_src0 <= 1'b0;
      uop_src1     <= '0;
      uop_has_src1 <= 1'b0;
      done         <= 1'b0;
      spawn_age    <= '0;
      stop_why     <= '0;
    end else begin
      uop_vld <= 1'b0;
      done    <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        age_q    <= '0;
        cnt_q    <= '0;
        need     <= '0;
        mem_pend <= 1'b0;
      end else if (busy_q) begin
        age_q <= age_q + AW'(1);
        if (take) begin
          uop_vld      <= 1'b1;
          uop_slot     <= CBW'(cnt_q);
          uop_kind     <= kind;
          uop_dst      <= u_dst;
          uop_src0     <= u_s0;
          uop_has_src0 <= u_h0;
          uop_src1     <= u_s1;
          uop_has_src1 <= u_h1;
          cnt_q        <= cnt_q + CW'(1);
          need         <= need_nx;
          if (opens_mem) mem_pend <= 1'b1;
        end
        if (finish) begin
          busy_q    <= 1'b0;
          done      <= 1'b1;
          spawn_age <= stop ? (age_q - AW'(1)) : age_q;
          stop_why  <= why;
        end
      end
    end
  end

  a_r2_rdy_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_rdy) |=> !req_rdy);

  a_r4_first_pwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_rdy) |=> ##1 (uop_vld && uop_kind == UK_PWRITE && uop_slot == '0));

  a_r6_pruned_no_src: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_vld && (uop_kind == UK_VPRED || uop_kind == UK_APLOAD)) |-> (!uop_has_src0 && !uop_has_src1));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (uop_total <= CW'(CB_DEPTH)));

  a_r2_rdy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_rdy);

endmodule

// File: rtl/slice_extractor.sv
module slice_extractor
  import slx_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int CB_DEPTH = 32,
  parameter int NREG     = 32,
  localparam int AW      = $clog2(DEPTH),
  localparam int RW      = $clog2(NREG),
  localparam int CBW     = (CB_DEPTH > 1) ? $clog2(CB_DEPTH) : 1,
  localparam int CW      = $clog2(CB_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ret_vld,
  input  logic [RW-1:0]  ret_dst,
  input  logic           ret_has_dst,
  input  logic [RW-1:0]  ret_src0,
  input  logic           ret_has_src0,
  input  logic [RW-1:0]  ret_src1,
  input  logic           ret_has_src1,
  input  logic           ret_is_load,
  input  logic           ret_is_store,
  input  logic           ret_mem_dep,
  input  logic           ret_in_scope,
  input  logic           ret_val_conf,
  input  logic           ret_addr_conf,
  input  logic           req_vld,
  output logic           req_rdy,
  output logic           uop_vld,
  output logic [CBW-1:0] uop_slot,
  output logic [1:0]     uop_kind,
  output logic [RW-1:0]  uop_dst,
  output logic [RW-1:0]  uop_src0,
  output logic           uop_has_src0,
  output logic [RW-1:0]  uop_src1,
  output logic           uop_has_src1,
  output logic           done,
  output logic [AW-1:0]  spawn_age,
  output logic [CW-1:0]  uop_total,
  output logic [1:0]     stop_why
);

  ent_flags_t      wr_flg, rd_flg;
  logic            hist_wr, rd_valid;
  logic [RW-1:0]   rd_dst, rd_s0, rd_s1;
  logic [AW-1:0]   scan_age, hist_head;
  logic            is_first, mem_pend, cb_full;
  logic [NREG-1:0] need, need_nx;
  logic            take, stop, opens_mem;
  stop_why_e       why;
  uop_kind_e       kind;
  logic [RW-1:0]   u_dst, u_s0, u_s1;
  logic            u_h0, u_h1;

  assign wr_flg = '{has_dst: ret_has_dst, has_s0: ret_has_src0, has_s1: ret_has_src1,
                    is_load: ret_is_load, is_store: ret_is_store, mem_dep: ret_mem_dep,
                    in_scope: ret_in_scope, val_conf: ret_val_conf, addr_conf: ret_addr_conf};

  // the buffer is frozen while a build runs; a request wins over a retire
  assign hist_wr = ret_vld && req_rdy && !req_vld;

  slx_history #(.DEPTH(DEPTH), .RW(RW)) hist_i (
    .clk(clk), .rst_n(rst_n), .wr_en(hist_wr),
    .wr_dst(ret_dst), .wr_s0(ret_src0), .wr_s1(ret_src1), .wr_flg(wr_flg),
    .rd_age(scan_age), .rd_valid(rd_valid),
    .rd_dst(rd_dst), .rd_s0(rd_s0), .rd_s1(rd_s1), .rd_flg(rd_flg),
    .head(hist_head)
  );

  slx_pick #(.NREG(NREG)) pick_i (
    .is_first(is_first), .ent_valid(rd_valid),
    .dst(rd_dst), .s0(rd_s0), .s1(rd_s1), .flg(rd_flg),
    .need(need), .mem_pend(mem_pend), .cb_full(cb_full),
    .take(take), .stop(stop), .why(why), .kind(kind),
    .need_nx(need_nx), .opens_mem(opens_mem),
    .u_dst(u_dst), .u_s0(u_s0), .u_h0(u_h0), .u_s1(u_s1), .u_h1(u_h1)
  );

  slx_scan #(.DEPTH(DEPTH), .CB_DEPTH(CB_DEPTH), .NREG(NREG)) scan_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
    .age(scan_age), .is_first(is_first), .need(need),
    .mem_pend(mem_pend), .cb_full(cb_full),
    .take(take), .stop(stop), .why(why), .kind(kind),
    .need_nx(need_nx), .opens_mem(opens_mem),
    .u_dst(u_dst), .u_s0(u_s0), .u_h0(u_h0), .u_s1(u_s1), .u_h1(u_h1),
    .uop_vld(uop_vld), .uop_slot(uop_slot), .uop_kind(uop_kind),
    .uop_dst(uop_dst), .uop_src0(uop_src0), .uop_has_src0(uop_has_src0),
    .uop_src1(uop_src1), .uop_has_src1(uop_has_src1),
    .done(done), .spawn_age(spawn_age), .uop_total(uop_total), .stop_why(stop_why)
  );

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rdy |=> $stable(hist_head));

endmodule

// File: tb/slice_extractor_tb.sv
module slice_extractor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 16;
  localparam int CB = 4;
  localparam int NR = 8;
  localparam int RW = 3;
  localparam int AW = 4;
  localparam int CBW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_vld = 0, ret_has_dst = 0, ret_has_src0 = 0, ret_has_src1 = 0;
  logic ret_is_load = 0, ret_is_store = 0, ret_mem_dep = 0, ret_in_scope = 0;
  logic ret_val_conf = 0, ret_addr_conf = 0, req_vld = 0;
  logic [RW-1:0] ret_dst = 0, ret_src0 = 0, ret_src1 = 0;
  logic req_rdy, uop_vld, uop_has_src0, uop_has_src1, done;
  logic [CBW-1:0] uop_slot;
  logic [1:0] uop_kind, stop_why;
  logic [RW-1:0] uop_dst, uop_src0, uop_src1;
  logic [AW-1:0] spawn_age;
  logic [CW-1:0] uop_total;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_extractor #(.DEPTH(D), .CB_DEPTH(CB), .NREG(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_dst(ret_dst), .ret_has_dst(ret_has_dst),
    .ret_src0(ret_src0), .ret_has_src0(ret_has_src0), .ret_src1(ret_src1), .ret_has_src1(ret_has_src1),
    .ret_is_load(ret_is_load), .ret_is_store(ret_is_store), .ret_mem_dep(ret_mem_dep),
    .ret_in_scope(ret_in_scope), .ret_val_conf(ret_val_conf), .ret_addr_conf(ret_addr_conf),
    .req_vld(req_vld), .req_rdy(req_rdy), .uop_vld(uop_vld), .uop_slot(uop_slot),
    .uop_kind(uop_kind), .uop_dst(uop_dst), .uop_src0(uop_src0), .uop_has_src0(uop_has_src0),
    .uop_src1(uop_src1), .uop_has_src1(uop_has_src1), .done(done), .spawn_age(spawn_age),
    .uop_total(uop_total), .stop_why(stop_why)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // model of the history: entries written in retire order
  int m_dst[D], m_s0[D], m_s1[D];
  bit m_hd[D], m_h0[D], m_h1[D], m_ld[D], m_st[D], m_md[D], m_sc[D], m_vc[D], m_ac[D];
  int m_head = 0, m_fill = 0;

  // expected build result
  int e_kind[CB], e_dst[CB], e_s0[CB], e_s1[CB];
  bit e_h0[CB], e_h1[CB];
  int e_n, e_why, e_spawn, e_visit;

  task automatic put(input int dst, input bit hd, input int s0, input bit h0, input int s1, input bit h1,
                     input bit ld, input bit st, input bit md, input bit sc, input bit vc, input bit ac);
    @(negedge clk);
    ret_vld = 1; ret_dst = dst[RW-1:0]; ret_has_dst = hd; ret_src0 = s0[RW-1:0]; ret_has_src0 = h0;
    ret_src1 = s1[RW-1:0]; ret_has_src1 = h1; ret_is_load = ld; ret_is_store = st; ret_mem_dep = md;
    ret_in_scope = sc; ret_val_conf = vc; ret_addr_conf = ac;
    m_dst[m_head] = dst; m_hd[m_head] = hd; m_s0[m_head] = s0; m_h0[m_head] = h0;
    m_s1[m_head] = s1; m_h1[m_head] = h1; m_ld[m_head] = ld; m_st[m_head] = st;
    m_md[m_head] = md; m_sc[m_head] = sc; m_vc[m_head] = vc; m_ac[m_head] = ac;
    m_head = (m_head + 1) % D;
    if (m_fill < D) m_fill++;
    @(negedge clk);
    ret_vld = 0;
  endtask

  task automatic fence();
    put(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // expected slice, walked from the requirements
  task automatic model();
    bit need[NR];
    bit pend;
    for (int r = 0; r < NR; r++) need[r] = 0;
    pend = 0; e_n = 0; e_why = 0; e_spawn = D - 1; e_visit = D;
    for (int a = 0; a < D; a++) begin
      int ix;
      ix = ((m_head - 1 - a) % D + D) % D;
      if (a == 0) begin
        e_kind[0] = 3; e_dst[0] = 0;
        e_h0[0] = m_h0[ix]; e_s0[0] = m_h0[ix] ? m_s0[ix] : 0;
        e_h1[0] = m_h1[ix]; e_s1[0] = m_h1[ix] ? m_s1[ix] : 0;
        if (m_h0[ix]) need[m_s0[ix]] = 1;
        if (m_h1[ix]) need[m_s1[ix]] = 1;
        e_n = 1;
      end else begin
        bit nd;
        if (a >= m_fill || !m_sc[ix]) begin e_why = 1; e_spawn = a - 1; e_visit = a + 1; break; end
        if (pend && m_st[ix])        begin e_why = 2; e_spawn = a - 1; e_visit = a + 1; break; end
        nd = m_hd[ix] && need[m_dst[ix]];
        if (nd && e_n == CB)         begin e_why = 3; e_spawn = a - 1; e_visit = a + 1; break; end
        if (nd) begin
          int k;
          bit keep;
          k = m_vc[ix] ? 1 : ((m_ld[ix] && m_ac[ix]) ? 2 : 0);
          keep = (k == 0);
          e_kind[e_n] = k; e_dst[e_n] = m_dst[ix];
          e_h0[e_n] = keep && m_h0[ix]; e_s0[e_n] = (keep && m_h0[ix]) ? m_s0[ix] : 0;
          e_h1[e_n] = keep && m_h1[ix]; e_s1[e_n] = (keep && m_h1[ix]) ? m_s1[ix] : 0;
          e_n++;
          need[m_dst[ix]] = 0;
          if (keep && m_h0[ix]) need[m_s0[ix]] = 1;
          if (keep && m_h1[ix]) need[m_s1[ix]] = 1;
          if (m_ld[ix] && m_md[ix] && !m_vc[ix]) pend = 1;
        end
      end
    end
  endtask

  task automatic build(input string tag, input bit hold_ret);
    int got, cyc;
    bit rdy_ok;
    model();
    @(negedge clk);
    chk(req_rdy == 1, {tag, " R2 ready before request"}, req_rdy, 1);
    req_vld = 1;
    if (hold_ret) begin
      ret_vld = 1; ret_dst = 3'd5; ret_has_dst = 1; ret_in_scope = 1;
      ret_has_src0 = 0; ret_has_src1 = 0; ret_is_store = 0; ret_is_load = 0;
      ret_val_conf = 0; ret_addr_conf = 0; ret_mem_dep = 0;
    end
    @(posedge clk);
    @(negedge clk);
    req_vld = 0;
    got = 0; cyc = 1; rdy_ok = 1;
    while (!done && cyc < 200) begin
      if (req_rdy) rdy_ok = 0;
      if (uop_vld) begin
        if (got < CB) begin
          chk(uop_slot == got, {tag, " R12 slot"}, uop_slot, got);
          chk(uop_kind == e_kind[got], {tag, " R5 kind"}, uop_kind, e_kind[got]);
          chk(uop_dst == e_dst[got], {tag, " R5 dst"}, uop_dst, e_dst[got]);
          chk(uop_has_src0 == e_h0[got] && uop_src0 == e_s0[got], {tag, " R6 src0"}, uop_src0, e_s0[got]);
          chk(uop_has_src1 == e_h1[got] && uop_src1 == e_s1[got], {tag, " R7 src1"}, uop_src1, e_s1[got]);
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    if (uop_vld) begin
      if (got < CB) begin
        chk(uop_slot == got, {tag, " R12 slot"}, uop_slot, got);
        chk(uop_kind == e_kind[got], {tag, " R5 kind"}, uop_kind, e_kind[got]);
        chk(uop_dst == e_dst[got], {tag, " R5 dst"}, uop_dst, e_dst[got]);
        chk(uop_has_src0 == e_h0[got] && uop_src0 == e_s0[got], {tag, " R6 src0"}, uop_src0, e_s0[got]);
        chk(uop_has_src1 == e_h1[got] && uop_src1 == e_s1[got], {tag, " R7 src1"}, uop_src1, e_s1[got]);
      end
      got++;
    end
    chk(done == 1, {tag, " R3 done seen"}, done, 1);
    chk(cyc == e_visit + 1, {tag, " R3 done cycle"}, cyc, e_visit + 1);
    chk(rdy_ok && req_rdy == 1, {tag, " R2 ready low while busy"}, req_rdy, 1);
    chk(got == e_n, {tag, " R12 uop count"}, got, e_n);
    chk(uop_total == e_n, {tag, " R12 uop_total"}, uop_total, e_n);
    chk(stop_why == e_why, {tag, " R8 stop cause"}, stop_why, e_why);
    chk(spawn_age == e_spawn, {tag, " R11 spawn age"}, spawn_age, e_spawn);
    ret_vld = 0;
    @(negedge clk);
    chk(done == 0, {tag, " R3 done single"}, done, 0);
  endtask

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic put_rand();
    int dst, s0, s1;
    bit st, ld, hd;
    rs = step(rs);
    dst = rs[2:0]; s0 = rs[5:3]; s1 = rs[8:6];
    st = (rs[11:9] == 0);
    ld = !st && (rs[13:12] == 0);
    hd = !st && (rs[16:14] != 0);
    put(dst, hd, s0, rs[17] | ld, s1, rs[18] & !ld, ld, st, ld & rs[19],
        rs[23:20] != 0, rs[26:24] == 0, rs[28:27] == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_rdy == 1, "R2 reset ready", req_rdy, 1);
    chk(done == 0, "R3 reset done", done, 0);
    chk(uop_vld == 0, "R12 reset uop_vld", uop_vld, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5 R8: plain chain ending at a scope fence
    fence();
    put(1, 1, 6, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(7, 1, 5, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(2, 1, 1, 1, 1, 1, 0, 0, 0, 1, 0, 0);
    put(0, 0, 2, 1, 3, 1, 0, 0, 0, 1, 0, 0);
    build("chain R4 R5 R8", 0);

    // R6: value-confident producer cuts its subtree
    fence();
    put(4, 1, 5, 1, 6, 1, 0, 0, 0, 1, 0, 0);
    put(3, 1, 4, 1, 4, 1, 0, 0, 0, 1, 1, 0);
    put(0, 0, 3, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    build("vpred R6", 0);

    // R7: address-confident load
    fence();
    put(5, 1, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(2, 1, 5, 1, 0, 0, 1, 0, 0, 1, 0, 1);
    put(0, 0, 2, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    build("apload R7", 0);

    // R9: memory dependency stops at the store
    fence();
    put(6, 1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(0, 0, 6, 1, 1, 1, 0, 1, 0, 1, 0, 0);
    put(3, 1, 6, 1, 0, 0, 1, 0, 1, 1, 0, 0);
    put(0, 0, 3, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    build("memdep R9", 0);

    // R10: construction buffer full
    fence();
    put(1, 1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(2, 1, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(3, 1, 2, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(4, 1, 3, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(5, 1, 4, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(0, 0, 5, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    build("full R10", 0);

    // R1 R11: overfill the buffer with in-scope entries
    for (int i = 0; i < D + 4; i++) put(7, 1, 6, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    build("end R1 R11", 0);

    // R2: retires held during a build are dropped
    fence();
    put(2, 1, 4, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    put(0, 0, 2, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    build("hold R2", 1);
    build("after hold R2", 0);

    // sweep of generated histories
    for (int t = 0; t < 80; t++) begin
      int n;
      rs = step(rs);
      n = 1 + rs[4:0] % 20;
      for (int j = 0; j < n; j++) put_rand();
      build("sweep R5 R8 R9 R10", t[0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule